// File: doc/BRIEF.md
# Overlay Pixel Decoder and Compositor

This block takes one raw overlay word per pixel and turns it into a 24-bit RGB colour with an 8-bit alpha. How the word is read depends on a bits-per-pixel setting and a colour mode. In indexed mode the colour comes from a 256-entry palette. The alpha combines a per-pixel value, a whole-overlay value and a colour-key match. The overlay colour is then blended over the video pixel that arrives with it.

Pixels enter and leave on valid/ready handshakes. The block is a two-stage pipeline. Stage one decodes the word, reads the palette and resolves the alpha. Stage two blends each channel. The palette is loaded in two steps: software first writes an index, then writes the colour that is stored at that index.

Top module: `ovl_compositor`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: When cfg_bpp_i is 01 (8 bpp), the colour mode setting is ignored and the pixel is treated as indexed. The palette address is word[7:0] and the upper 24 bits are ignored. A palette entry holds alpha in [31:24] and R,G,B in [23:16],[15:8],[7:0].
- R3: Indexed mode (cfg_mode_i 000) at 32 bpp (cfg_bpp_i 11) uses only word[7:0]. The three upper bytes are padding.
- R4: Mode 001 (565) reads R=word[15:11], G=word[10:5], B=word[4:0] and ignores word[31:16]. Channels are widened by appending their top bits (5 bit: {v,v[4:2]}, 6 bit: {v,v[5:4]}). Local alpha is always 255.
- R5: Mode 010 (555) reads R=[14:10], G=[9:5], B=[4:0]. When word[15] is 1, local alpha is 0; when it is 0, local alpha is 255.
- R6: Mode 011 (444) reads R=[11:8], G=[7:4], B=[3:0], each widened to {v,v}. If any of word[15:12] is 1, local alpha is 0; otherwise it is 255.
- R7: Mode 100 (8888) takes local alpha from word[31:24] and R,G,B from word[23:0].
- R8: Effective alpha is round(la*ga/255). Here la is the local alpha, or 255 when cfg_local_en_i is 0. ga is cfg_galpha_i, or 255 when cfg_global_en_i is 0.
- R9: When cfg_key_en_i is 1 and the pixel matches the key, alpha is forced to 0. In the 16-bit modes the compare uses word[15:0] against key[15:0]. Indexed mode compares the index with key[7:0], and 8888 compares all 32 bits. When cfg_key_en_i is 0, keying has no effect.
- R10: Each output channel is round((a*ov + (255-a)*vid)/255). With a=0 the output equals the video; with a=255 it equals the overlay.
- R11: A pulse on pal_idx_we_i latches pal_wdata_i[7:0] as the palette index. A later pulse on pal_data_we_i stores pal_wdata_i at that index.
- R12: A pixel accepted at one rising edge appears on out_pix_o with out_valid_o at the next rising edge. While out_ready_i is 0, the output holds steady and in_ready_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 3 | Colour mode |
| cfg_bpp_i | input | 2 | Bits per pixel: 01=8, 10=16, 11=32 |
| cfg_key_en_i | input | 1 | Colour key enable |
| cfg_local_en_i | input | 1 | Per-pixel alpha enable |
| cfg_global_en_i | input | 1 | Whole-overlay alpha enable |
| cfg_key_i | input | 32 | Key value |
| cfg_galpha_i | input | 8 | Whole-overlay alpha |
| pal_idx_we_i | input | 1 | Palette index write strobe |
| pal_data_we_i | input | 1 | Palette colour write strobe |
| pal_wdata_i | input | 32 | Palette write data |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted |
| in_word_i | input | 32 | Raw overlay word |
| in_video_i | input | 24 | Underlying video pixel, RGB |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_pix_o | output | 24 | Blended RGB pixel |

## Verification
A pixel offered at one rising edge is accepted there and becomes visible on the outputs after the following rising edge. Each scenario drives at a falling edge, lets two rising edges pass, and samples at the next falling edge. Configuration and palette writes are settled at least one edge before the pixel is offered. The stall scenario holds out_ready_i low for several cycles and samples the held output and in_ready_o at falling edges before releasing it.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [2:0] {
    MODE_IDX  = 3'b000,
    MODE_565  = 3'b001,
    MODE_555  = 3'b010,
    MODE_444  = 3'b011,
    MODE_8888 = 3'b100
  } ovl_mode_e;

  localparam logic [1:0] BPP_8 = 2'b01;

  // round(x/255), exact for x <= 255*255
  function automatic logic [7:0] div255(input logic [16:0] x);
    logic [17:0] t;
    logic [17:0] s;
    t = {1'b0, x} + 18'd128;
    s = (t + (t >> 8)) >> 8;
    return s[7:0];
  endfunction

  function automatic logic [7:0] wid4(input logic [3:0] v);
    return {v, v};
  endfunction

  function automatic logic [7:0] wid5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] wid6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction
endpackage

// File: rtl/ovl_palette.sv
module ovl_palette #(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned DW      = 32,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_we_i,
  input  logic          data_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [AW-1:0] wr_idx_q;
  logic [DW-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_idx_q <= '0;
    else if (idx_we_i) wr_idx_q <= wdata_i[AW-1:0];
  end

  // data write uses the index latched before this cycle
  always_ff @(posedge clk_i) begin
    if (data_we_i) mem_q[wr_idx_q] <= wdata_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];

  a_r11_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |=> mem_q[$past(wr_idx_q)] == $past(wdata_i));
endmodule

// File: rtl/ovl_decode.sv
module ovl_decode
  import ovl_pkg::*;
(
  input  logic [2:0]  mode_i,
  input  logic [1:0]  bpp_i,
  input  logic [31:0] word_i,
  input  logic [31:0] key_i,
  input  logic [31:0] pal_i,
  output logic [7:0]  pal_addr_o,
  output logic [23:0] rgb_o,
  output logic [7:0]  la_o,
  output logic        key_hit_o
);
  ovl_mode_e mode_eff;

  assign pal_addr_o = word_i[7:0];

  always_comb begin
    mode_eff = (bpp_i == BPP_8) ? MODE_IDX : ovl_mode_e'(mode_i);
    case (mode_eff)
      MODE_IDX: begin
        rgb_o     = pal_i[23:0];
        la_o      = pal_i[31:24];
        key_hit_o = word_i[7:0] == key_i[7:0];
      end
      MODE_565: begin
        rgb_o     = {wid5(word_i[15:11]), wid6(word_i[10:5]), wid5(word_i[4:0])};
        la_o      = 8'hFF;
        key_hit_o = word_i[15:0] == key_i[15:0];
      end
      MODE_555: begin
        rgb_o     = {wid5(word_i[14:10]), wid5(word_i[9:5]), wid5(word_i[4:0])};
        la_o      = word_i[15] ? 8'h00 : 8'hFF;
        key_hit_o = word_i[15:0] == key_i[15:0];
      end
      MODE_444: begin
        rgb_o     = {wid4(word_i[11:8]), wid4(word_i[7:4]), wid4(word_i[3:0])};
        la_o      = (|word_i[15:12]) ? 8'h00 : 8'hFF;
        key_hit_o = word_i[15:0] == key_i[15:0];
      end
      default: begin
        rgb_o     = word_i[23:0];
        la_o      = word_i[31:24];
        key_hit_o = word_i == key_i;
      end
    endcase
  end
endmodule

// File: rtl/ovl_blend.sv
module ovl_blend
  import ovl_pkg::*;
#(
  parameter int unsigned CHANNELS = 3,
  parameter int unsigned CW       = 8,
  localparam int unsigned PW      = CHANNELS * CW
) (
  input  logic [CW-1:0] alpha_i,
  input  logic [PW-1:0] ovl_i,
  input  logic [PW-1:0] vid_i,
  output logic [PW-1:0] pix_o
);
  logic [CW-1:0] inv_alpha;
  assign inv_alpha = ~alpha_i;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic [16:0] mix;
    always_comb begin
      mix = 17'(alpha_i * ovl_i[c*CW +: CW]) + 17'(inv_alpha * vid_i[c*CW +: CW]);
      pix_o[c*CW +: CW] = div255(mix);
    end
  end
endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
  import ovl_pkg::*;
#(
  parameter int unsigned PAL_ENTRIES = 256,
  parameter int unsigned PIX_W       = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cfg_mode_i,
  input  logic [1:0]       cfg_bpp_i,
  input  logic             cfg_key_en_i,
  input  logic             cfg_local_en_i,
  input  logic             cfg_global_en_i,
  input  logic [31:0]      cfg_key_i,
  input  logic [7:0]       cfg_galpha_i,
  input  logic             pal_idx_we_i,
  input  logic             pal_data_we_i,
  input  logic [31:0]      pal_wdata_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [31:0]      in_word_i,
  input  logic [PIX_W-1:0] in_video_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [PIX_W-1:0] out_pix_o
);
  localparam int unsigned PAL_AW = $clog2(PAL_ENTRIES);

  logic [PAL_AW-1:0] pal_addr;
  logic [31:0]       pal_rd;
  logic [23:0]       dec_rgb;
  logic [7:0]        dec_la, la_eff, ga_eff, alpha_d;
  logic              dec_hit, adv;

  logic              s1_valid;
  logic [23:0]       s1_rgb;
  logic [PIX_W-1:0]  s1_video;
  logic [7:0]        s1_alpha;
  logic [PIX_W-1:0]  blend_pix;

  ovl_palette #(.ENTRIES(PAL_ENTRIES), .DW(32)) u_pal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_we_i  (pal_idx_we_i),
    .data_we_i (pal_data_we_i),
    .wdata_i   (pal_wdata_i),
    .rd_addr_i (pal_addr),
    .rd_data_o (pal_rd)
  );

  logic [7:0] dec_addr;
  ovl_decode u_dec (
    .mode_i     (cfg_mode_i),
    .bpp_i      (cfg_bpp_i),
    .word_i     (in_word_i),
    .key_i      (cfg_key_i),
    .pal_i      (pal_rd),
    .pal_addr_o (dec_addr),
    .rgb_o      (dec_rgb),
    .la_o       (dec_la),
    .key_hit_o  (dec_hit)
  );
  assign pal_addr = dec_addr[PAL_AW-1:0];

  always_comb begin
    la_eff  = cfg_local_en_i  ? dec_la       : 8'hFF;
    ga_eff  = cfg_global_en_i ? cfg_galpha_i : 8'hFF;
    alpha_d = (cfg_key_en_i && dec_hit) ? 8'h00 : div255(17'(la_eff * ga_eff));
  end

  // whole pipe advances together; stalls only when the output is held
  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_rgb   <= '0;
      s1_video <= '0;
      s1_alpha <= '0;
    end else if (adv) begin
      s1_valid <= in_valid_i;
      s1_rgb   <= dec_rgb;
      s1_video <= in_video_i;
      s1_alpha <= alpha_d;
    end
  end

  ovl_blend #(.CHANNELS(3), .CW(8)) u_blend (
    .alpha_i (s1_alpha),
    .ovl_i   (s1_rgb),
    .vid_i   (s1_video),
    .pix_o   (blend_pix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_pix_o   <= '0;
    end else if (adv) begin
      out_valid_o <= s1_valid;
      out_pix_o   <= blend_pix;
    end
  end

  a_r10_clear_passes_video: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && s1_valid && s1_alpha == 8'h00) |=> out_pix_o == $past(s1_video));

  a_r10_solid_passes_overlay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && s1_valid && s1_alpha == 8'hFF) |=> out_pix_o == $past(s1_rgb));

  a_r12_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_pix_o)));

  a_r12_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !s1_valid) |=> !out_valid_o);

  a_r9_key_clears_alpha: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && in_valid_i && cfg_key_en_i && dec_hit) |=> s1_alpha == 8'h00);
endmodule

// File: tb/tb_ovl_compositor.sv
module tb_ovl_compositor;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [1:0]  bpp = 2'b11;
  logic        key_en = 1'b0, local_en = 1'b1, global_en = 1'b0;
  logic [31:0] key = '0;
  logic [7:0]  galpha = 8'hFF;
  logic        idx_we = 1'b0, data_we = 1'b0;
  logic [31:0] wdata = '0;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_word = '0;
  logic [23:0] in_video = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [23:0] out_pix;

  int vectors = 0;
  int errors = 0;
  logic [31:0] pal_sh [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  ovl_compositor dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_mode_i(mode), .cfg_bpp_i(bpp), .cfg_key_en_i(key_en),
    .cfg_local_en_i(local_en), .cfg_global_en_i(global_en),
    .cfg_key_i(key), .cfg_galpha_i(galpha),
    .pal_idx_we_i(idx_we), .pal_data_we_i(data_we), .pal_wdata_i(wdata),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_word_i(in_word),
    .in_video_i(in_video), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_pix_o(out_pix)
  );

  function automatic int rnd255(int x);
    return (2 * x + 255) / 510;
  endfunction

  function automatic logic [23:0] model(logic [31:0] w, logic [23:0] v);
    int la, ga, a, m;
    logic hit;
    logic [23:0] rgb, res;
    m = (bpp == 2'b01) ? 0 : int'(mode);
    case (m)
      0: begin rgb = pal_sh[w[7:0]][23:0]; la = pal_sh[w[7:0]][31:24]; hit = (w[7:0] == key[7:0]); end
      1: begin rgb = {w[15:11], w[15:13], w[10:5], w[10:9], w[4:0], w[4:2]}; la = 255; hit = (w[15:0] == key[15:0]); end
      2: begin rgb = {w[14:10], w[14:12], w[9:5], w[9:7], w[4:0], w[4:2]}; la = w[15] ? 0 : 255; hit = (w[15:0] == key[15:0]); end
      3: begin rgb = {w[11:8], w[11:8], w[7:4], w[7:4], w[3:0], w[3:0]}; la = (w[15:12] != 0) ? 0 : 255; hit = (w[15:0] == key[15:0]); end
      default: begin rgb = w[23:0]; la = w[31:24]; hit = (w == key); end
    endcase
    if (!local_en) la = 255;
    ga = global_en ? int'(galpha) : 255;
    a = rnd255(la * ga);
    if (key_en && hit) a = 0;
    for (int c = 0; c < 3; c++)
      res[c*8 +: 8] = 8'(rnd255(a * int'(rgb[c*8 +: 8]) + (255 - a) * int'(v[c*8 +: 8])));
    return res;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pal_write(logic [7:0] idx, logic [31:0] col);
    @(negedge clk); idx_we = 1'b1; wdata = {24'h0, idx};
    @(negedge clk); idx_we = 1'b0; data_we = 1'b1; wdata = col;
    @(negedge clk); data_we = 1'b0; wdata = 32'hDEAD_BEEF;
    pal_sh[idx] = col;
  endtask

  task automatic send(string req, logic [31:0] w, logic [23:0] v);
    logic [23:0] exp;
    exp = model(w, v);
    @(negedge clk); in_valid = 1'b1; in_word = w; in_video = v;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    check({req, " valid"}, {31'h0, out_valid}, 32'h1);
    check(req, {8'h0, out_pix}, {8'h0, exp});
    @(negedge clk);
    check({req, " drained"}, {31'h0, out_valid}, 32'h0);
  endtask

  task automatic t_reset();
    check("R1 out_valid", {31'h0, out_valid}, 32'h0);
    check("R1 in_ready", {31'h0, in_ready}, 32'h1);
  endtask

  task automatic t_palette();
    pal_write(8'h05, 32'hFF10_2030);
    pal_write(8'h80, 32'h80A0_B0C0);
    bpp = 2'b01; mode = 3'd4;
    send("R11 R2 idx5 bpp8", 32'hABCD_EF05, 24'h000000);
    check("R11 R2 direct", {8'h0, model(32'h05, 24'h0)}, 32'h0010_2030);
    send("R2 idx80 blend", 32'h1122_3380, 24'hFFFFFF);
    bpp = 2'b11; mode = 3'd0;
    send("R3 padding", 32'h1234_5680, 24'h102030);
  endtask

  task automatic t_modes();
    bpp = 2'b10; mode = 3'd1;
    send("R4 565", 32'h5A5A_F81F, 24'h123456);
    send("R4 565 mid", 32'h0000_8410, 24'h000000);
    mode = 3'd2;
    send("R5 555 clear", 32'h0000_FFFF, 24'h445566);
    send("R5 555 solid", 32'h0000_7C1F, 24'h445566);
    mode = 3'd3;
    send("R6 444 clear", 32'h0000_1ABC, 24'h0A0B0C);
    send("R6 444 solid", 32'hFFFF_0ABC, 24'h0A0B0C);
    bpp = 2'b11; mode = 3'd4;
    send("R7 8888", 32'h40FF_8000, 24'h00FF80);
  endtask

  task automatic t_alpha();
    bpp = 2'b11; mode = 3'd4; global_en = 1'b1; galpha = 8'h80;
    send("R8 local*global", 32'h80F0_1020, 24'h204060);
    local_en = 1'b0;
    send("R8 global only", 32'h00F0_1020, 24'h204060);
    global_en = 1'b0;
    send("R8 local off", 32'h00F0_1020, 24'h204060);
    local_en = 1'b1;
    bpp = 2'b10; mode = 3'd2; local_en = 1'b0;
    send("R5 R8 switch ignored", 32'h0000_FC00, 24'h010203);
    local_en = 1'b1;
  endtask

  task automatic t_key();
    bpp = 2'b10; mode = 3'd1; key = 32'hABCD_F81F; key_en = 1'b1;
    send("R9 565 hit", 32'h0000_F81F, 24'h336699);
    send("R9 565 miss", 32'h0000_F81E, 24'h336699);
    key_en = 1'b0;
    send("R9 key off", 32'h0000_F81F, 24'h336699);
    bpp = 2'b11; mode = 3'd4; key = 32'hFF11_2233; key_en = 1'b1;
    send("R9 8888 hit", 32'hFF11_2233, 24'h0);
    send("R9 8888 upper differs", 32'hFE11_2233, 24'h0);
    key_en = 1'b0;
  endtask

  task automatic t_stall();
    logic [23:0] exp;
    bpp = 2'b11; mode = 3'd4;
    exp = model(32'hFF12_3456, 24'h0);
    @(negedge clk); out_ready = 1'b0; in_valid = 1'b1; in_word = 32'hFF12_3456; in_video = 24'h0;
    @(negedge clk); in_word = 32'hFF65_4321;
    @(negedge clk);
    check("R12 first out", {8'h0, out_pix}, {8'h0, exp});
    check("R12 ready low", {31'h0, in_ready}, 32'h0);
    repeat (3) @(negedge clk);
    check("R12 held", {8'h0, out_pix}, {8'h0, exp});
    check("R12 held valid", {31'h0, out_valid}, 32'h1);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R12 second out", {8'h0, out_pix}, 32'h0065_4321);
    @(negedge clk);
    check("R12 empty", {31'h0, out_valid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_palette();
    t_modes();
    t_alpha();
    t_key();
    t_stall();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule